// File: doc/BRIEF.md
# Descriptor Ready Polling Controller

This block decides when a communication channel reads its buffer descriptors back from memory to learn whether they can be used. Software writes a small mode register. One bit in it turns transmit polling on. While that bit is set, the transmit fetch engine reads descriptors one after another. Each read returns a single ready bit. A ready descriptor moves the transmit index forward and polling goes on. A descriptor that is not ready clears the enable bit in hardware, and transmit polling then stops until software sets it again.

The receive fetch engine reads an empty flag from each descriptor. A polarity bit in the mode register sets whether 1 or 0 means empty. The same bit also keeps receive polling running even when the enable bit is clear. A descriptor that holds data produces a one-cycle hit pulse and moves the receive index forward. An empty descriptor is fetched again.

Each direction has its own fetch port. A request uses valid/ready: the request, with its descriptor index, stays asserted and unchanged until ready is high on a clock edge. The response is a single-cycle valid with the status bit and has no back-pressure. Each channel has at most one fetch outstanding, and a response that arrives while no fetch is outstanding is dropped.

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset, the enable bit and the polarity bit are 0, both descriptor indices are 0, and neither channel asserts a fetch request.
- R2: Mode register layout: bit 0 is the poll enable, bit 3 is the receive polarity, and bits 2:1 always read 11 whatever is written. All other bits read 0, so the reset value is 0x06.
- R3: A transmit fetch request starts only while the enable bit is 1. With the enable bit at 0, no transmit fetch is made.
- R4: A transmit response with ready bit 0 clears the enable bit on the next edge and leaves the transmit index unchanged.
- R5: A transmit response with ready bit 1 leaves the enable bit set and advances the transmit index by one, wrapping at the depth.
- R6: A register write with bit 0 = 1 in the same cycle as a hardware clear leaves the enable bit at 1.
- R7: With polarity 0, a receive status bit of 1 means empty, and receive fetches start only while the enable bit is 1.
- R8: With polarity 1, a receive status bit of 0 means empty, and receive fetches start whatever the enable bit holds.
- R9: A receive response that is not empty pulses rx_hit for one cycle and advances the receive index, wrapping at the depth. An empty response leaves the index unchanged, and polling goes on.
- R10: After a request is accepted, that channel asserts no new request until its response has returned.
- R11: A request that is not accepted stays valid and keeps the same index on the next cycle.
- R12: A response valid that arrives while the channel has no outstanding fetch changes neither the index nor the enable bit, and produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | CFG_W | Mode register write data |
| cfg_rdata | output | CFG_W | Mode register read-back |
| tx_req_valid | output | 1 | Transmit descriptor fetch request |
| tx_req_ready | input | 1 | Transmit fetch request accepted |
| tx_req_idx | output | TX_IW | Transmit descriptor index (current pointer) |
| tx_rsp_valid | input | 1 | Transmit fetch response valid |
| tx_rsp_bit | input | 1 | Ready bit of the fetched transmit descriptor |
| tx_hit | output | 1 | Pulse: ready transmit descriptor found |
| rx_req_valid | output | 1 | Receive descriptor fetch request |
| rx_req_ready | input | 1 | Receive fetch request accepted |
| rx_req_idx | output | RX_IW | Receive descriptor index (current pointer) |
| rx_rsp_valid | input | 1 | Receive fetch response valid |
| rx_rsp_bit | input | 1 | Raw empty flag of the fetched receive descriptor |
| rx_hit | output | 1 | Pulse: receive descriptor holding data found |

## Verification
A table walks every pairing of polarity, enable, transmit ready bit and receive status bit. This separates polling that depends on the enable bit from polling forced by polarity, shows that an active-low empty flag is decoded correctly, and confirms that only a not-ready transmit descriptor stops polling. An index model driven by the returned bits checks advance and hold across wrap-around. Directed patterns cover requests held under back-pressure, one outstanding fetch per channel, a software set that collides with the hardware clear, and a response that arrives while nothing is outstanding.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  // mode register bit positions (software decodes them)
  localparam int CfgPenBit   = 0;
  localparam int CfgFixLo    = 1;
  localparam int CfgFixHi    = 2;
  localparam int CfgRxNegBit = 3;
  localparam logic [1:0] CfgFixVal = 2'b11;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/dpoll_mode_reg.sv
module dpoll_mode_reg
  import dpoll_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             auto_clr,
  output logic             poll_en,
  output logic             rx_neg,
  output logic [CFG_W-1:0] rd_data
);
  logic pen_q, neg_q;
  logic set_pen;
  logic cfg_unused;

  assign set_pen    = wr_en & wr_data[CfgPenBit];
  assign cfg_unused = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      if (wr_en) begin
        pen_q <= wr_data[CfgPenBit];
        neg_q <= wr_data[CfgRxNegBit];
      end
      // a software set outranks the hardware clear
      if (auto_clr && !set_pen) pen_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[CfgPenBit]          = pen_q;
    rd_data[CfgFixHi:CfgFixLo]  = CfgFixVal;
    rd_data[CfgRxNegBit]        = neg_q;
  end

  assign poll_en = pen_q;
  assign rx_neg  = neg_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CfgPenBit]) |=> poll_en);

  // R4
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && !(wr_en && wr_data[CfgPenBit])) |=> !poll_en);
endmodule

// File: rtl/dpoll_fetch_eng.sv
module dpoll_fetch_eng
  import dpoll_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          hit_level,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [IW-1:0] req_idx,
  input  logic          rsp_valid,
  input  logic          rsp_bit,
  output logic          done,
  output logic          hit
);
  localparam logic [IW-1:0] LastIdx = IW'(DEPTH - 1);

  fetch_st_e     state_q;
  logic [IW-1:0] idx_q;

  assign done      = (state_q == FS_WAIT) && rsp_valid;
  assign hit       = done && (rsp_bit == hit_level);
  assign req_valid = (state_q == FS_REQ);
  assign req_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (enable) state_q <= FS_REQ;
        FS_REQ:  if (req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (rsp_valid) begin
          state_q <= FS_IDLE;
          if (rsp_bit == hit_level)
            idx_q <= (idx_q == LastIdx) ? '0 : idx_q + 1'b1;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_idx)));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R12
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FS_WAIT && rsp_valid) |=> $stable(req_idx));
endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int  CFG_W    = 8,
  parameter int  TX_DEPTH = 4,
  parameter int  RX_DEPTH = 4,
  localparam int TX_IW    = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1,
  localparam int RX_IW    = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             tx_req_valid,
  input  logic             tx_req_ready,
  output logic [TX_IW-1:0] tx_req_idx,
  input  logic             tx_rsp_valid,
  input  logic             tx_rsp_bit,
  output logic             tx_hit,
  output logic             rx_req_valid,
  input  logic             rx_req_ready,
  output logic [RX_IW-1:0] rx_req_idx,
  input  logic             rx_rsp_valid,
  input  logic             rx_rsp_bit,
  output logic             rx_hit
);
  logic poll_en, rx_neg;
  logic tx_done, tx_live, rx_done;
  logic tx_clr, rx_go;

  // a finished transmit fetch that did not find a ready descriptor
  assign tx_clr = tx_done & ~tx_live;
  // receive polling: enable bit, or forced by the active-low polarity
  assign rx_go  = poll_en | rx_neg;
  assign tx_hit = tx_live;

  dpoll_mode_reg #(.CFG_W(CFG_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .auto_clr (tx_clr),
    .poll_en  (poll_en),
    .rx_neg   (rx_neg),
    .rd_data  (cfg_rdata)
  );

  dpoll_fetch_eng #(.DEPTH(TX_DEPTH), .IW(TX_IW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (poll_en),
    .hit_level (1'b1),
    .req_valid (tx_req_valid),
    .req_ready (tx_req_ready),
    .req_idx   (tx_req_idx),
    .rsp_valid (tx_rsp_valid),
    .rsp_bit   (tx_rsp_bit),
    .done      (tx_done),
    .hit       (tx_live)
  );

  // not-empty level equals the polarity bit: pol 0 -> 0 holds data, pol 1 -> 1 holds data
  dpoll_fetch_eng #(.DEPTH(RX_DEPTH), .IW(RX_IW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rx_go),
    .hit_level (rx_neg),
    .req_valid (rx_req_valid),
    .req_ready (rx_req_ready),
    .req_idx   (rx_req_idx),
    .rsp_valid (rx_rsp_valid),
    .rsp_bit   (rx_rsp_bit),
    .done      (rx_done),
    .hit       (rx_hit)
  );

  // R3
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_valid) |-> $past(poll_en));

  // R7 R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req_valid) |-> $past(poll_en || rx_neg));

  // R9
  rx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |-> rx_done);
endmodule

// File: tb/dpoll_ctrl_tb_top.sv
module dpoll_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_req_valid, tx_hit, rx_req_valid, rx_hit;
  logic       tx_req_ready = 1'b1;
  logic       rx_req_ready = 1'b1;
  logic [1:0] tx_req_idx, rx_req_idx;
  logic       tx_rsp_valid = 1'b0, tx_rsp_bit = 1'b0;
  logic       rx_rsp_valid = 1'b0, rx_rsp_bit = 1'b0;

  int errors = 0, checks = 0;
  int tx_cnt, rx_cnt, tx_hit_cnt, rx_hit_cnt;
  bit tx_pend = 0, rx_pend = 0, auto_rsp = 1;
  bit force_tx = 0, force_tx_bit = 0;
  bit v_tx_bit = 0, v_rx_bit = 0, m_rxneg = 0;
  logic [1:0] tx_model = '0, rx_model = '0;

  always #4 clk = ~clk;

  dpoll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready),
    .tx_req_idx(tx_req_idx), .tx_rsp_valid(tx_rsp_valid), .tx_rsp_bit(tx_rsp_bit),
    .tx_hit(tx_hit), .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready),
    .rx_req_idx(rx_req_idx), .rx_rsp_valid(rx_rsp_valid), .rx_rsp_bit(rx_rsp_bit),
    .rx_hit(rx_hit)
  );

  // {rx polarity, enable, tx ready bit, rx status bit, expected enable after, expected rx fetches}
  localparam logic [5:0] VEC [8] = '{
    6'b0010_00, 6'b0110_11, 6'b0101_01, 6'b0111_11,
    6'b1001_01, 6'b1010_01, 6'b1111_11, 6'b1100_01
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus plus memory responder, driven at the falling edge
  task automatic cyc(input bit we, input logic [7:0] d);
    @(negedge clk);
    cfg_we = we; cfg_wdata = d;
    tx_rsp_valid = 0; rx_rsp_valid = 0;
    if (force_tx) begin
      tx_rsp_valid = 1; tx_rsp_bit = force_tx_bit;
      if (tx_pend) begin
        if (force_tx_bit) tx_model = tx_model + 1'b1;
        tx_pend = 0;
      end
      force_tx = 0;
    end else if (auto_rsp && tx_pend) begin
      tx_rsp_valid = 1; tx_rsp_bit = v_tx_bit;
      if (v_tx_bit) tx_model = tx_model + 1'b1;
      tx_pend = 0;
    end
    if (auto_rsp && rx_pend) begin
      rx_rsp_valid = 1; rx_rsp_bit = v_rx_bit;
      if (v_rx_bit == m_rxneg) rx_model = rx_model + 1'b1;
      rx_pend = 0;
    end
    if (tx_req_valid && tx_req_ready) begin tx_pend = 1; tx_cnt++; end
    if (rx_req_valid && rx_req_ready) begin rx_pend = 1; rx_cnt++; end
    if (we) m_rxneg = d[3];
    #1;
    if (tx_hit) tx_hit_cnt++;
    if (rx_hit) rx_hit_cnt++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 R2 reset state
    chk(cfg_rdata == 8'h06, "R1 R2 reset readback", cfg_rdata, 8'h06);
    chk(!tx_req_valid && !rx_req_valid, "R1 no request", {tx_req_valid, rx_req_valid}, 0);
    chk(tx_req_idx == 0 && rx_req_idx == 0, "R1 indices", {tx_req_idx, rx_req_idx}, 0);

    // R2 fixed bits ignore writes, other bits read 0
    cyc(1, 8'hF8); cyc(0, 0); #1;
    chk(cfg_rdata == 8'h0E, "R2 readback", cfg_rdata, 8'h0E);
    cyc(1, 8'h00);
    repeat (10) cyc(0, 0);
    chk(cfg_rdata == 8'h06, "R2 cleared readback", cfg_rdata, 8'h06);

    // vector walk
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      v_tx_bit = v[3]; v_rx_bit = v[2];
      tx_cnt = 0; rx_cnt = 0; tx_hit_cnt = 0; rx_hit_cnt = 0;
      cyc(1, {4'b0, v[5], 2'b00, v[4]});
      repeat (24) cyc(0, 0);
      chk(cfg_rdata[0] == v[1], v[3] ? "R5 enable kept" : "R4 enable cleared", cfg_rdata[0], v[1]);
      chk((tx_cnt > 0) == v[4], "R3 tx fetch gating", tx_cnt, v[4]);
      chk((rx_cnt > 0) == v[0], v[5] ? "R8 rx forced polling" : "R7 rx gated polling", rx_cnt, v[0]);
      chk((rx_hit_cnt > 0) == (v[0] && (v[2] == v[5])), "R9 rx hit", rx_hit_cnt, v[0] && (v[2] == v[5]));
      chk((tx_hit_cnt > 0) == (v[4] && v[3]), "R5 tx hit", tx_hit_cnt, v[4] && v[3]);
      cyc(1, 8'h00);
      repeat (10) cyc(0, 0);
      chk(tx_req_idx == tx_model, "R5 tx index", tx_req_idx, tx_model);
      chk(rx_req_idx == rx_model, "R9 rx index", rx_req_idx, rx_model);
    end

    // R11 back-pressure, R10 single outstanding
    auto_rsp = 0; tx_req_ready = 0;
    cyc(1, 8'h01);
    repeat (6) cyc(0, 0);
    chk(tx_req_valid == 1'b1, "R11 request held", tx_req_valid, 1);
    chk(tx_req_idx == tx_model, "R11 index stable", tx_req_idx, tx_model);
    tx_req_ready = 1;
    cyc(0, 0);
    repeat (4) cyc(0, 0);
    chk(tx_req_valid == 1'b0, "R10 no second request", tx_req_valid, 0);

    // R6 software set collides with hardware clear
    force_tx = 1; force_tx_bit = 0;
    cyc(1, 8'h01);
    cyc(0, 0);
    chk(cfg_rdata[0] == 1'b1, "R6 set wins", cfg_rdata[0], 1);
    chk(tx_req_idx == tx_model, "R4 index held", tx_req_idx, tx_model);

    // R4 plain clear
    while (!tx_pend) cyc(0, 0);
    force_tx = 1; force_tx_bit = 0;
    cyc(0, 0);
    cyc(0, 0);
    chk(cfg_rdata[0] == 1'b0, "R4 enable cleared", cfg_rdata[0], 0);
    repeat (4) cyc(0, 0);

    // R12 stray response
    tx_hit_cnt = 0;
    force_tx = 1; force_tx_bit = 1;
    cyc(0, 0);
    cyc(0, 0);
    chk(tx_req_idx == tx_model, "R12 index unchanged", tx_req_idx, tx_model);
    chk(tx_hit_cnt == 0, "R12 no hit", tx_hit_cnt, 0);
    chk(cfg_rdata[0] == 1'b0, "R12 enable unchanged", cfg_rdata[0], 0);
    auto_rsp = 1;
    repeat (6) cyc(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule